// File: doc/BRIEF.md
# Slave-mode FPGA configuration engine

This block loads bitstreams into one or more downstream FPGAs that are strapped for slave configuration. A host processor writes bitstream words into an internal FIFO through a small register port, selects the interface mode, and issues one start command. The engine then runs the whole load by itself. It pulses the active-low program line and waits for the target's active-low init line to fall and rise again. After that it clocks the data out, either over a parallel bus of 8, 16 or 32 bits with a one-hot active-low chip select, or bit-serially to a daisy chain. Finally it watches the done input and finishes with a few trailing clocks.

An optional bit-order swap reverses the bits inside every byte on the way out, so the host can push files in either byte bit order. In the parallel modes the host can abort a load in progress. The engine then flips the bus to read and packs the status bytes the target returns into a register. A write to the reset register returns the engine to idle and empties the FIFO.

Top module: `cfg_slave_ctrl`

## Requirements
- R1: Control register (address 0) field bits [3:2] selects the mode: 0 = parallel 8-bit, 1 = parallel 16-bit, 2 = parallel 32-bit, 3 = serial. A parallel mode presents one FIFO word per configuration clock rising edge on `cfg_d_o`, low 8/16/32 bits, with the unused upper bits zero and the read/write select low (write). Data is stable while `cfg_cclk_o` is high.
- R2: In serial mode each FIFO word goes out on `cfg_sdata_o` most significant bit first, one bit per rising edge of `cfg_cclk_o`, 32 edges per word.
- R3: Control bit 4 set reverses the bit order inside each byte of every word before it is driven (bit 0 and bit 7 of a byte trade places, and so on). Cleared, words pass unchanged.
- R4: Writing control with bit 0 set while idle drives `cfg_prog_no` low for exactly PROG_CYC clock cycles. No configuration clock edge occurs until init has gone low and returned high.
- R5: If init stays low for INIT_TMO cycles after the program pulse, the engine stops without clocking data and sets the error status bit.
- R6: Init going low while data is being transferred sets the error status bit and stops the transfer.
- R7: Configuration clock edges occur only while the FIFO holds data. With an empty FIFO the clock pauses and resumes when a word arrives.
- R8: When done rises during transfer, exactly EXTRA_CLK further clock edges are issued and then the done status bit is set.
- R9: Chip select outputs are active low. In parallel modes only output `k` is low during transfer, where `k` is control field bits [8 +: DEV_W]. In serial mode all chip selects stay high.
- R10: Writing control with bit 1 set during a parallel transfer raises chip select for one cycle with read/write switched to read and the data bus released. The engine then reads ABORT_WORDS bytes from `cfg_rb_i`, one per clock edge, and packs them first-byte-most-significant into the abort register (address 4). It sets the aborted status bit and returns to idle. The same request in serial mode has no effect.
- R11: The status register (address 2) holds idle in bit 0, done in bit 1, error in bit 2, aborted in bit 3, FIFO full in bit 4, FIFO almost full (at least DEPTH-1 words) in bit 5 and FIFO empty in bit 6. Writes to the FIFO (address 3) while it is full are dropped.
- R12: Any write to the reset register (address 1) returns the engine to idle, clears done, error and aborted, and empties the FIFO. A start while in the done or error state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| cfg_prog_no | output | 1 | Program request to targets, active low |
| cfg_init_ni | input | 1 | Init handshake from targets, active low |
| cfg_done_i | input | 1 | Done from targets |
| cfg_cclk_o | output | 1 | Configuration clock |
| cfg_d_o | output | 32 | Parallel configuration data |
| cfg_d_oe_o | output | 1 | Parallel data drive enable |
| cfg_rb_i | input | 8 | Readback byte from target during abort |
| cfg_rdwr_o | output | 1 | Read/write select, 1 = read |
| cfg_cs_no | output | N_DEV | Per-device chip selects, active low |
| cfg_sdata_o | output | 1 | Serial configuration data |

## Verification
The bench sweeps every mode against both swap settings with different device selects. It rebuilds each captured word from the clock edges and compares it with the arithmetically swapped and masked pattern. A wrong bit order, a swap applied across the whole word or an off-by-one width mask shows up as a word mismatch. The remaining checks cover edge counts and status codes at the corner points. The FIFO is starved mid-load, where a design that clocked stale data would show extra edges. Init is held low or dropped mid-load, where a design that missed it would never flag error. The FIFO is overfilled, where a dropped-write bug gives one edge too many. A parallel abort is checked for the packed readback order, and a serial abort must leave the engine untouched.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    MODE_P8  = 2'd0,
    MODE_P16 = 2'd1,
    MODE_P32 = 2'd2,
    MODE_SER = 2'd3
  } cfg_mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WLO, S_WHI, S_XFER, S_DCLK, S_FIN, S_ERR, S_ACS, S_ARD
  } cfg_state_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_RST    = 3'd1;
  localparam logic [2:0] A_STATUS = 3'd2;
  localparam logic [2:0] A_FIFO   = 3'd3;
  localparam logic [2:0] A_ABORT  = 3'd4;
endpackage

// File: rtl/cfg_fifo.sv
module cfg_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         afull_o,
  output logic         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign afull_o = (cnt_q >= CW'(DEPTH - 1));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/cfg_bitswap.sv
module cfg_bitswap #(
  parameter int unsigned W = 32
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  localparam int unsigned NB = W / 8;
  logic [W-1:0] rev;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign rev[b*8 + i] = d_i[b*8 + 7 - i];
    end
  end

  assign d_o = en_i ? rev : d_i;
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_pkg::*;
#(
  parameter int unsigned N_DEV       = 4,
  parameter int unsigned PROG_CYC    = 16,
  parameter int unsigned INIT_TMO    = 4096,
  parameter int unsigned EXTRA_CLK   = 8,
  parameter int unsigned ABORT_WORDS = 4,
  localparam int unsigned DEV_W      = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int unsigned ABT_W      = 8 * ABORT_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              soft_rst_i,
  input  cfg_mode_e         mode_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] head_i,
  output logic              pop_o,
  input  logic              init_ni,
  input  logic              done_i,
  input  logic [7:0]        rb_i,
  output logic              prog_no,
  output logic              cclk_o,
  output logic [DATA_W-1:0] d_o,
  output logic              oe_o,
  output logic              sdata_o,
  output logic              rdwr_o,
  output logic [N_DEV-1:0]  cs_no,
  output logic              idle_o,
  output logic              done_o,
  output logic              err_o,
  output logic              abt_o,
  output logic [ABT_W-1:0]  abort_o
);
  localparam int unsigned MAXC = (INIT_TMO > PROG_CYC) ?
                                 ((INIT_TMO > EXTRA_CLK) ? INIT_TMO : EXTRA_CLK) :
                                 ((PROG_CYC > EXTRA_CLK) ? PROG_CYC : EXTRA_CLK);
  localparam int unsigned CW = $clog2(MAXC + ABORT_WORDS + 1);
  localparam int unsigned BW = $clog2(DATA_W);
  localparam logic [CW-1:0] PROG_END = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] TMO_END  = CW'(INIT_TMO - 1);
  localparam logic [CW-1:0] XTR_END  = CW'(EXTRA_CLK - 1);
  localparam logic [CW-1:0] ABT_END  = CW'(ABORT_WORDS - 1);
  localparam logic [BW-1:0] BIT_END  = BW'(DATA_W - 1);

  cfg_state_e         state_q;
  logic [CW-1:0]      cnt_q;
  logic [BW-1:0]      bit_q;
  logic               ph_q, cclk_q, sdat_q;
  logic [DATA_W-1:0]  d_q;
  logic               done_q, err_q, abt_q;
  logic [ABT_W-1:0]   abort_q;
  logic               par, abort_ok, edge_go;
  logic [DATA_W-1:0]  masked;

  assign par      = (mode_i != MODE_SER);
  assign abort_ok = abort_i && par;
  // rising-edge phase of a data transfer, nothing pre-empting it
  assign edge_go  = (state_q == S_XFER) && init_ni && !abort_ok && !done_i && ph_q;
  assign pop_o    = edge_go && (par || (bit_q == BIT_END));

  always_comb begin
    unique case (mode_i)
      MODE_P8:  masked = {{(DATA_W-8){1'b0}},  head_i[7:0]};
      MODE_P16: masked = {{(DATA_W-16){1'b0}}, head_i[15:0]};
      default:  masked = head_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      ph_q    <= 1'b0;
      cclk_q  <= 1'b0;
      sdat_q  <= 1'b0;
      d_q     <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abt_q   <= 1'b0;
      abort_q <= '0;
    end else if (soft_rst_i) begin
      state_q <= S_IDLE;
      ph_q    <= 1'b0;
      cclk_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          cclk_q <= 1'b0;
          ph_q   <= 1'b0;
          if (start_i) begin
            state_q <= S_PROG;
            cnt_q   <= '0;
            bit_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            abt_q   <= 1'b0;
            abort_q <= '0;
          end
        end
        S_PROG: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == PROG_END) state_q <= S_WLO;
        end
        S_WLO: begin
          cnt_q <= '0;
          if (!init_ni) state_q <= S_WHI;
        end
        S_WHI: begin
          if (init_ni) begin
            state_q <= S_XFER;
          end else if (cnt_q == TMO_END) begin
            state_q <= S_ERR;
            err_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_XFER: begin
          if (!init_ni) begin
            state_q <= S_ERR;
            err_q   <= 1'b1;
            cclk_q  <= 1'b0;
          end else if (abort_ok) begin
            state_q <= S_ACS;
            cclk_q  <= 1'b0;
          end else if (done_i) begin
            state_q <= S_DCLK;
            cnt_q   <= '0;
            cclk_q  <= 1'b0;
            ph_q    <= 1'b0;
          end else if (!ph_q) begin
            cclk_q <= 1'b0;
            if (!fifo_empty_i) begin
              ph_q   <= 1'b1;
              d_q    <= masked;
              sdat_q <= head_i[BIT_END - bit_q];
            end
          end else begin
            cclk_q <= 1'b1;
            ph_q   <= 1'b0;
            if (!par) bit_q <= bit_q + 1'b1;
          end
        end
        S_DCLK: begin
          ph_q <= !ph_q;
          if (!ph_q) begin
            cclk_q <= 1'b0;
          end else begin
            cclk_q <= 1'b1;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == XTR_END) begin
              state_q <= S_FIN;
              done_q  <= 1'b1;
            end
          end
        end
        S_ACS: begin
          state_q <= S_ARD;
          ph_q    <= 1'b0;
          cnt_q   <= '0;
        end
        S_ARD: begin
          ph_q <= !ph_q;
          if (!ph_q) begin
            cclk_q <= 1'b0;
          end else begin
            cclk_q  <= 1'b1;
            cnt_q   <= cnt_q + 1'b1;
            abort_q <= {abort_q[ABT_W-9:0], rb_i};
            if (cnt_q == ABT_END) begin
              state_q <= S_IDLE;
              abt_q   <= 1'b1;
            end
          end
        end
        default: cclk_q <= 1'b0;  // S_FIN, S_ERR hold until reset
      endcase
    end
  end

  logic cs_act;
  assign cs_act  = par && (state_q inside {S_XFER, S_DCLK, S_ARD});
  for (genvar k = 0; k < N_DEV; k++) begin : g_cs
    assign cs_no[k] = !(cs_act && (dev_i == DEV_W'(k)));
  end

  assign prog_no = (state_q != S_PROG);
  assign cclk_o  = cclk_q;
  assign d_o     = d_q;
  assign sdata_o = sdat_q;
  assign oe_o    = par && (state_q inside {S_XFER, S_DCLK});
  assign rdwr_o  = (state_q inside {S_ACS, S_ARD});
  assign idle_o  = (state_q == S_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign abt_o   = abt_q;
  assign abort_o = abort_q;

  p_cs_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_no) <= 1);
  p_ser_no_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SER) |-> (&cs_no));
  p_no_clk_in_prog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> !cclk_o);
  p_data_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_o |-> ($stable(d_o) && $stable(sdata_o)));
  p_read_released_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdwr_o |-> !oe_o);
  p_crc_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    (state_q == S_XFER && !init_ni) |=> err_o);
endmodule

// File: rtl/cfg_slave_ctrl.sv
module cfg_slave_ctrl
  import cfg_pkg::*;
#(
  parameter int unsigned N_DEV       = 4,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned PROG_CYC    = 16,
  parameter int unsigned INIT_TMO    = 4096,
  parameter int unsigned EXTRA_CLK   = 8,
  parameter int unsigned ABORT_WORDS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             cfg_prog_no,
  input  logic             cfg_init_ni,
  input  logic             cfg_done_i,
  output logic             cfg_cclk_o,
  output logic [31:0]      cfg_d_o,
  output logic             cfg_d_oe_o,
  input  logic [7:0]       cfg_rb_i,
  output logic             cfg_rdwr_o,
  output logic [N_DEV-1:0] cfg_cs_no,
  output logic             cfg_sdata_o
);
  localparam int unsigned DEV_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int unsigned ABT_W = 8 * ABORT_WORDS;

  cfg_mode_e         mode_q;
  logic              swap_q;
  logic [DEV_W-1:0]  dev_q;
  logic              wr_ctrl, start, abort, soft_rst, push;
  logic              full, afull, empty, pop;
  logic [DATA_W-1:0] head_raw, head;
  logic              idle, done, err, abt;
  logic [ABT_W-1:0]  abort_val;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == A_CTRL);
  assign start    = wr_ctrl && reg_wdata_i[0];
  assign abort    = wr_ctrl && reg_wdata_i[1];
  assign soft_rst = reg_we_i && (reg_addr_i == A_RST);
  assign push     = reg_we_i && (reg_addr_i == A_FIFO) && !full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_P8;
      swap_q <= 1'b0;
      dev_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= cfg_mode_e'(reg_wdata_i[3:2]);
      swap_q <= reg_wdata_i[4];
      dev_q  <= reg_wdata_i[8 +: DEV_W];
    end
  end

  cfg_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst),
    .push_i  (push),
    .wdata_i (reg_wdata_i),
    .pop_i   (pop),
    .head_o  (head_raw),
    .full_o  (full),
    .afull_o (afull),
    .empty_o (empty)
  );

  cfg_bitswap #(.W(DATA_W)) u_swap (
    .en_i (swap_q),
    .d_i  (head_raw),
    .d_o  (head)
  );

  cfg_seq #(
    .N_DEV       (N_DEV),
    .PROG_CYC    (PROG_CYC),
    .INIT_TMO    (INIT_TMO),
    .EXTRA_CLK   (EXTRA_CLK),
    .ABORT_WORDS (ABORT_WORDS)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .abort_i      (abort),
    .soft_rst_i   (soft_rst),
    .mode_i       (mode_q),
    .dev_i        (dev_q),
    .fifo_empty_i (empty),
    .head_i       (head),
    .pop_o        (pop),
    .init_ni      (cfg_init_ni),
    .done_i       (cfg_done_i),
    .rb_i         (cfg_rb_i),
    .prog_no      (cfg_prog_no),
    .cclk_o       (cfg_cclk_o),
    .d_o          (cfg_d_o),
    .oe_o         (cfg_d_oe_o),
    .sdata_o      (cfg_sdata_o),
    .rdwr_o       (cfg_rdwr_o),
    .cs_no        (cfg_cs_no),
    .idle_o       (idle),
    .done_o       (done),
    .err_o        (err),
    .abt_o        (abt),
    .abort_o      (abort_val)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[3:2]          = mode_q;
        reg_rdata_o[4]            = swap_q;
        reg_rdata_o[8 +: DEV_W]   = dev_q;
      end
      A_STATUS: reg_rdata_o[6:0] = {empty, afull, full, abt, err, done, idle};
      A_ABORT:  reg_rdata_o      = 32'(abort_val);
      default:  reg_rdata_o      = '0;
    endcase
  end

  p_start_leaves_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start && !soft_rst) |=> !cfg_prog_no);
endmodule

// File: tb/tb_cfg_slave_ctrl.sv
module tb_cfg_slave_ctrl;
  localparam int N_DEV = 3, DEPTH = 8, PROG_CYC = 4, INIT_TMO = 40;
  localparam int EXTRA_CLK = 6, ABORT_WORDS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic prog_n, init_n, done_in = 1'b0, cclk, oe, rdwr, sdata;
  logic [31:0] d_o;
  logic [7:0] rb;
  logic [N_DEV-1:0] cs_n;

  cfg_slave_ctrl #(.N_DEV(N_DEV), .DEPTH(DEPTH), .PROG_CYC(PROG_CYC),
    .INIT_TMO(INIT_TMO), .EXTRA_CLK(EXTRA_CLK), .ABORT_WORDS(ABORT_WORDS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cfg_prog_no(prog_n),
    .cfg_init_ni(init_n), .cfg_done_i(done_in), .cfg_cclk_o(cclk),
    .cfg_d_o(d_o), .cfg_d_oe_o(oe), .cfg_rb_i(rb), .cfg_rdwr_o(rdwr),
    .cfg_cs_no(cs_n), .cfg_sdata_o(sdata));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // target model: init follows program, then lingers low a few cycles
  int hold = 0;
  logic force_low = 1'b0;
  always @(negedge clk) begin
    if (!prog_n) hold <= 5;
    else if (hold > 0) hold <= hold - 1;
  end
  assign init_n = !((hold > 0) || !prog_n || force_low);

  int edge_cnt = 0, early = 0, ab_base = 0, prog_low = 0, rd_cyc = 0;
  bit cs_hi_rd = 1'b0;
  logic [31:0] cap_d [256];
  logic        cap_s [256];
  always @(posedge cclk) begin
    cap_d[edge_cnt & 255] = d_o;
    cap_s[edge_cnt & 255] = sdata;
    if (!init_n) early++;
    edge_cnt++;
  end
  always @(posedge rdwr) ab_base = edge_cnt;
  assign rb = 8'hA0 + 8'(edge_cnt - ab_base);
  always @(negedge clk) begin
    if (!prog_n) prog_low++;
    if (rdwr) rd_cyc++;
    if (rdwr && (&cs_n)) cs_hi_rd = 1'b1;
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask
  task automatic wait_edges(input int base, input int n);
    for (int i = 0; i < 4000 && (edge_cnt - base) < n; i++) @(negedge clk);
  endtask
  task automatic wait_stat(input logic [31:0] mask);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < 4000 && ((s & mask) == 0); i++) reg_rd(3'd2, s);
  endtask

  function automatic logic [31:0] pat(input int m, input int s, input int i);
    return 32'h8C3A51E7 ^ (32'(i) * 32'h1F2E3D4B) ^ (32'(m) * 32'h01010101) ^ (32'(s) << 9);
  endfunction
  function automatic logic [31:0] swp(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++) r[b*8 + k] = w[b*8 + 7 - k];
    return r;
  endfunction
  function automatic logic [31:0] msk(input int m, input logic [31:0] w);
    if (m == 0) return {24'h0, w[7:0]};
    if (m == 1) return {16'h0, w[15:0]};
    return w;
  endfunction

  task automatic run_cfg(input int m, input int s, input int dev, input int n);
    logic [31:0] st, cfg, expw, got;
    int base, pl0, per;
    cfg = 32'(dev << 8) | 32'(s << 4) | 32'(m << 2);
    per = (m == 3) ? 32 : 1;
    reg_wr(3'd1, 0);
    reg_wr(3'd0, cfg);
    for (int i = 0; i < n; i++) reg_wr(3'd3, pat(m, s, i));
    base = edge_cnt; pl0 = prog_low;
    reg_wr(3'd0, cfg | 32'h1);
    wait_edges(base, n * per);
    chk(prog_low - pl0 == PROG_CYC, "R4 prog pulse length", 32'(prog_low - pl0), PROG_CYC);
    @(negedge clk);
    chk(cs_n == ((m == 3) ? 3'b111 : ~(3'b001 << dev)), "R9 chip select", 32'(cs_n),
        32'((m == 3) ? 3'b111 : ~(3'b001 << dev)));
    chk(rdwr == 1'b0, "R1 write select", 32'(rdwr), 0);
    done_in = 1'b1;
    wait_stat(32'h2);
    done_in = 1'b0;
    chk(edge_cnt - base == n * per + EXTRA_CLK, "R8 edge count", 32'(edge_cnt - base),
        32'(n * per + EXTRA_CLK));
    reg_rd(3'd2, st);
    chk(st == 32'h42, "R8 done status", st, 32'h42);
    for (int i = 0; i < n; i++) begin
      expw = pat(m, s, i);
      if (s != 0) expw = swp(expw);
      if (m == 3) begin
        got = '0;
        for (int k = 0; k < 32; k++) got[31 - k] = cap_s[(base + i * 32 + k) & 255];
        chk(got == expw, (s != 0) ? "R2 R3 serial word" : "R2 serial word", got, expw);
      end else begin
        got = cap_d[(base + i) & 255];
        chk(got == msk(m, expw), (s != 0) ? "R1 R3 parallel word" : "R1 parallel word",
            got, msk(m, expw));
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] st;
    int base, pl0, rd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_rd(3'd2, st);
    chk(st == 32'h41, "R11 reset status", st, 32'h41);
    chk(prog_n && !cclk && (cs_n == 3'b111), "R9 reset pins",
        {29'h0, prog_n, cclk, &cs_n}, 32'h5);

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++) run_cfg(m, s, (m + s) % 3, 3);
    chk(early == 0, "R4 no clock before init high", 32'(early), 0);

    // R11 FIFO flags and dropped write
    reg_wr(3'd1, 0);
    for (int i = 0; i < DEPTH - 1; i++) reg_wr(3'd3, pat(2, 0, i));
    reg_rd(3'd2, st);
    chk(st == 32'h21, "R11 almost full", st, 32'h21);
    reg_wr(3'd3, pat(2, 0, DEPTH - 1));
    reg_rd(3'd2, st);
    chk(st == 32'h31, "R11 full", st, 32'h31);
    reg_wr(3'd3, 32'hDEADBEEF);
    reg_wr(3'd0, 32'h8);
    base = edge_cnt;
    reg_wr(3'd0, 32'h9);
    wait_edges(base, DEPTH);
    repeat (40) @(negedge clk);
    chk(edge_cnt - base == DEPTH, "R11 write dropped when full", 32'(edge_cnt - base), DEPTH);
    chk(cap_d[(base + DEPTH - 1) & 255] == pat(2, 0, DEPTH - 1), "R11 last word",
        cap_d[(base + DEPTH - 1) & 255], pat(2, 0, DEPTH - 1));

    // R7 pause on empty FIFO, R6 init low mid-transfer, R12 start ignored
    reg_wr(3'd1, 0);
    reg_wr(3'd0, 32'h8);
    reg_wr(3'd3, 32'h11112222);
    base = edge_cnt;
    reg_wr(3'd0, 32'h9);
    wait_edges(base, 1);
    repeat (30) @(negedge clk);
    chk(edge_cnt - base == 1, "R7 clock paused", 32'(edge_cnt - base), 1);
    reg_wr(3'd3, 32'h33334444);
    wait_edges(base, 2);
    repeat (10) @(negedge clk);
    chk(edge_cnt - base == 2 && cap_d[(base + 1) & 255] == 32'h33334444, "R7 resumed",
        cap_d[(base + 1) & 255], 32'h33334444);
    force_low = 1'b1;
    wait_stat(32'h4);
    reg_rd(3'd2, st);
    chk(st == 32'h44, "R6 error status", st, 32'h44);
    chk(edge_cnt - base == 2, "R6 transfer stopped", 32'(edge_cnt - base), 2);
    force_low = 1'b0;
    pl0 = prog_low;
    reg_wr(3'd0, 32'h9);
    repeat (10) @(negedge clk);
    reg_rd(3'd2, st);
    chk(prog_low == pl0 && st == 32'h44, "R12 start ignored in error", st, 32'h44);
    reg_wr(3'd1, 0);
    reg_rd(3'd2, st);
    chk(st == 32'h41, "R12 reset to idle", st, 32'h41);

    // R5 init timeout
    force_low = 1'b1;
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd3, 32'h5A5A5A5A);
    base = edge_cnt;
    reg_wr(3'd0, 32'h1);
    wait_stat(32'h4);
    reg_rd(3'd2, st);
    chk(st == 32'h04, "R5 timeout error", st, 32'h04);
    chk(edge_cnt == base, "R5 no clocks", 32'(edge_cnt - base), 0);
    force_low = 1'b0;
    reg_wr(3'd1, 0);

    // R10 parallel abort
    reg_wr(3'd0, 32'h204);
    reg_wr(3'd3, 32'hCAFE1234);
    base = edge_cnt;
    reg_wr(3'd0, 32'h205);
    wait_edges(base, 1);
    base = edge_cnt;
    reg_wr(3'd0, 32'h206);
    wait_stat(32'h1);
    reg_rd(3'd4, st);
    chk(st == 32'hA0A1A2A3, "R10 abort readback", st, 32'hA0A1A2A3);
    reg_rd(3'd2, st);
    chk(st == 32'h49, "R10 aborted status", st, 32'h49);
    chk(edge_cnt - base == ABORT_WORDS, "R10 read edges", 32'(edge_cnt - base), ABORT_WORDS);
    chk(cs_hi_rd, "R10 chip select released", 32'(cs_hi_rd), 1);

    // R10 serial abort ignored
    reg_wr(3'd1, 0);
    reg_wr(3'd0, 32'hC);
    reg_wr(3'd3, 32'h0F0F00FF);
    base = edge_cnt;
    reg_wr(3'd0, 32'hD);
    wait_edges(base, 32);
    rd0 = rd_cyc;
    reg_wr(3'd0, 32'hE);
    repeat (20) @(negedge clk);
    reg_rd(3'd2, st);
    chk(st == 32'h40 && rd_cyc == rd0, "R10 serial abort ignored", st, 32'h40);
    done_in = 1'b1;
    wait_stat(32'h2);
    done_in = 1'b0;
    chk(edge_cnt - base == 32 + EXTRA_CLK, "R10 serial finishes", 32'(edge_cnt - base),
        32 + EXTRA_CLK);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule